// File: doc/BRIEF.md
# Per-Field Cyclic Capture Scheduler

This block steers a video capture path one field at a time. A host loads a table with one entry per video field, enough for one second of video. At every rising edge of the field-sync input the block steps to the next entry and presents that entry's settings as registered outputs. The settings are the video source, the resolution, the pixel format, the compression enable and the destination virtual channel identifier. Capture is enabled only when the entry is marked valid and its source and format codes are legal.

The table wraps after the last field of the second. A mode input places that wrap after 60 entries for 60 Hz video or after 50 entries for 50 Hz video. Host writes go into a shadow table. The shadow table is copied into the working table only when the pointer wraps to entry 0. A schedule that is partly rewritten therefore never drives capture, and the host has to act only when it wants a different schedule.

Top module: `field_sched`

## Requirements
- R1: A rising edge of `fsync` seen at a clock edge advances `field_idx` by one and loads that entry's settings onto the outputs at the same clock edge.
- R2: When `ntsc` is 1, the entry after index 59 is 0. When `ntsc` is 0, the entry after index 49 is 0. Any index at or above the active wrap point steps to 0.
- R3: Between rising edges of `fsync`, every output holds its value.
- R4: `cap_en` is 1 only when three conditions all hold: the entry's valid bit is 1, its source code is 0, 1 or 2, and its format code is at most 4. The format codes are 0 for 24-bit RGB, 1 for 15-bit RGB, 2 for 8-bit RGB, 3 for 8-bit monochrome and 4 for 16-bit YUV.
- R5: An entry word has this layout: bit 24 is the valid bit, bits 23:22 are the source, bits 21:19 the format, bits 18:17 the resolution, bit 16 the compress flag and bits 15:0 the VCI. Each field appears unchanged on its output port.
- R6: Writes land in a shadow table. The working table takes the whole shadow table at the wrap to entry 0, and entry 0 of the new period already shows the new contents. Until that wrap, fields are taken from the old table.
- R7: A write with `wr_addr` of 60 or more has no effect on any entry.
- R8: After reset, all settings outputs and `cap_en` are 0 and `field_idx` is 59. The first rising edge of `fsync` wraps to entry 0 and loads the shadow table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Field sync, synchronous to clk |
| ntsc | input | 1 | 1 selects a 60-entry cycle, 0 selects a 50-entry cycle |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 6 | Table write index |
| wr_data | input | 25 | Entry word |
| cap_en | output | 1 | Capture enable for the current field |
| src | output | 2 | Source select |
| fmt | output | 3 | Pixel format code |
| res | output | 2 | Resolution select |
| cmp | output | 1 | Compression enable |
| vci | output | 16 | Destination VCI |
| field_idx | output | 6 | Index of the entry now driving the outputs |

## Verification
The checker finds a rising edge of `fsync` by comparing the port with its value one clock earlier. It therefore takes for granted that `fsync` is already synchronous to `clk` and is held low during reset, so that the first cycle after reset cannot look like a false edge. The stimulus drives `fsync` on falling clock edges and keeps it low through reset. It holds each pulse high for a single cycle and low for at least two, and it changes `ntsc` only between pulses.

// File: rtl/field_sched.sv
module field_sched #(
  parameter int DEPTH     = 60,
  parameter int SHORT_LEN = 50,
  parameter int VCI_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fsync,
  input  logic                     ntsc,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [VCI_W+8:0]         wr_data,
  output logic                     cap_en,
  output logic [1:0]               src,
  output logic [2:0]               fmt,
  output logic [1:0]               res,
  output logic                     cmp,
  output logic [VCI_W-1:0]         vci,
  output logic [$clog2(DEPTH)-1:0] field_idx
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = VCI_W + 9;

  logic [EW-1:0] shadow [DEPTH];
  logic [EW-1:0] active [DEPTH];
  logic          fs_q;

  wire          rise = fsync & ~fs_q;
  wire [AW-1:0] last = ntsc ? AW'(DEPTH - 1) : AW'(SHORT_LEN - 1);
  wire          wrap = field_idx >= last;
  wire [AW-1:0] nxt  = wrap ? '0 : field_idx + 1'b1;
  wire [EW-1:0] sel  = wrap ? shadow[0] : active[nxt];

  wire          s_ok = sel[EW-2 -: 2] != 2'd3;
  wire          f_ok = sel[EW-4 -: 3] <= 3'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
    end else if (wr_en && wr_addr < AW'(DEPTH)) begin
      shadow[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) active[i] <= '0;
    end else if (rise && wrap) begin
      for (int i = 0; i < DEPTH; i++) active[i] <= shadow[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q      <= 1'b0;
      field_idx <= AW'(DEPTH - 1);
      cap_en    <= 1'b0;
      src       <= '0;
      fmt       <= '0;
      res       <= '0;
      cmp       <= 1'b0;
      vci       <= '0;
    end else begin
      fs_q <= fsync;
      if (rise) begin
        field_idx <= nxt;
        cap_en    <= sel[EW-1] & s_ok & f_ok;
        src       <= sel[EW-2 -: 2];
        fmt       <= sel[EW-4 -: 3];
        res       <= sel[EW-7 -: 2];
        cmp       <= sel[VCI_W];
        vci       <= sel[VCI_W-1:0];
      end
    end
  end
endmodule

// File: rtl/field_sched_chk.sv
module field_sched_chk #(
  parameter int DEPTH     = 60,
  parameter int SHORT_LEN = 50,
  parameter int VCI_W     = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     fsync,
  input logic                     ntsc,
  input logic                     cap_en,
  input logic [1:0]               src,
  input logic [2:0]               fmt,
  input logic [1:0]               res,
  input logic                     cmp,
  input logic [VCI_W-1:0]         vci,
  input logic [$clog2(DEPTH)-1:0] field_idx
);
  localparam int AW = $clog2(DEPTH);
  logic          fs_prev;
  wire  [AW-1:0] lastw = ntsc ? AW'(DEPTH - 1) : AW'(SHORT_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) fs_prev <= 1'b0;
    else        fs_prev <= fsync;
  end

  wire edge_now = fsync & ~fs_prev;

  a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_now && field_idx < lastw) |=> field_idx == $past(field_idx) + 1'b1);

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_now && field_idx >= lastw) |=> field_idx == '0);

  a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
    field_idx <= AW'(DEPTH - 1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_now |=> ($stable(field_idx) && $stable(vci) && $stable(cap_en) &&
                   $stable(src) && $stable(fmt) && $stable(res) && $stable(cmp)));

  a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (src != 2'd3 && fmt <= 3'd4));
endmodule

bind field_sched field_sched_chk #(.DEPTH(DEPTH), .SHORT_LEN(SHORT_LEN), .VCI_W(VCI_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .ntsc(ntsc), .cap_en(cap_en),
  .src(src), .fmt(fmt), .res(res), .cmp(cmp), .vci(vci), .field_idx(field_idx)
);

// File: tb/test_field_sched.sv
module test_field_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        ntsc = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [24:0] wr_data = '0;
  logic        cap_en, cmp;
  logic [1:0]  src, res;
  logic [2:0]  fmt;
  logic [15:0] vci;
  logic [5:0]  field_idx;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  field_sched i_field_sched (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .ntsc(ntsc), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cap_en(cap_en), .src(src), .fmt(fmt),
    .res(res), .cmp(cmp), .vci(vci), .field_idx(field_idx)
  );

  function automatic logic [24:0] ent(int k, int g);
    logic v = ((k + g) % 7) != 3;
    logic [1:0] s = 2'((k + g) % 4);
    logic [2:0] f = 3'((k * 3 + g) % 8);
    logic [1:0] r = 2'(k % 4);
    logic c = 1'((k + g) % 2);
    logic [15:0] id = 16'(k * 257 + g * 1000 + 5);
    return {v, s, f, r, c, id};
  endfunction

  function automatic logic [30:0] expv(int k, int g);
    logic [24:0] e = ent(k, g);
    logic ce = e[24] && e[23:22] != 2'd3 && e[21:19] <= 3'd4;
    return {ce, e[23:0], 6'(k)};
  endfunction

  function automatic logic [30:0] outv();
    return {cap_en, src, fmt, res, cmp, vci, field_idx};
  endfunction

  task automatic chk(bit ok, string req, logic [30:0] act, logic [30:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(int g);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = 6'(k); wr_data = ent(k, g);
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic junk();
    for (int a = 60; a < 64; a++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = 6'(a); wr_data = 25'h1FFFFFF;
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); fsync = 1'b1;
    @(negedge clk); fsync = 1'b0;
    @(negedge clk);
  endtask

  task automatic step(int k, int g, string req);
    logic [30:0] a;
    pulse();
    a = outv();
    chk(a == expv(k, g), req, a, expv(k, g));
  endtask

  initial begin
    logic [30:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outv() == {25'd0, 6'd59}, "R8 reset", outv(), {25'd0, 6'd59});
    load(0);
    junk();
    chk(outv() == {25'd0, 6'd59}, "R3 no edge after writes", outv(), {25'd0, 6'd59});
    step(0, 0, "R8 first edge wraps to shadow entry 0");
    for (int k = 1; k < 60; k++) begin
      if (k == 11) load(1);
      step(k, 0, (k > 11) ? "R6 old table until wrap" : "R1 R4 R5 R7 sweep");
      if (k % 10 == 5) begin
        snap = outv();
        repeat (4) @(negedge clk);
        chk(outv() == snap, "R3 hold", outv(), snap);
      end
    end
    step(0, 1, "R6 new table at wrap R2 ntsc");
    for (int k = 1; k <= 55; k++) step(k, 1, "R1 R5 second period");
    @(negedge clk); ntsc = 1'b0;
    step(0, 1, "R2 index above short wrap point");
    junk();
    for (int k = 1; k < 50; k++) step(k, 1, "R2 R4 R7 short cycle");
    step(0, 1, "R2 wrap after 49");
    step(1, 1, "R1 after short wrap");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule